// File: doc/BRIEF.md
# Conveyor Reject Tracker

This block follows defective items along a conveyor so that an ejector can remove them at a point downstream of the inspection sensor. A single-cycle fault pulse from the inspection sensor plants a 1 in the first stage of a tracking shift register. Every item that moves past, good or defective, produces a single-cycle move pulse, and each move pulse advances the register by one stage. When a planted 1 sits in the reject stage, the reject command is raised.

The reject command stays up until a removal sensor confirms the ejection. A removal pulse sets an internal acknowledge flag that forces the command low. The next move pulse clears the flag, so the command can rise again for the next flagged item. A fault pulse that coincides with a move pulse is deferred until after the shift within the same update. This keeps the new entry from colliding with the shift. A synchronous clear input and the active-low reset empty the register and drop the flag. All inputs are assumed to be synchronous single-cycle pulses.

Top module: `reject_tracker`

## Requirements
- R1: While rst_n is low at a rising clock edge, every bit of track_o becomes 0 and reject_o is 0 after that edge, whatever the other inputs are.
- R2: A fault_i pulse with move_i low sets track_o[0] to 1 after the edge and leaves track_o[DEPTH-1:1] unchanged.
- R3: A move_i pulse moves each bit to the next higher index of track_o. Bit 0 receives 0 unless a fault is entered, and the bit at index DEPTH-1 is dropped.
- R4: When fault_i and move_i are both high in one cycle, the shift is applied first and track_o[0] is then 1.
- R5: reject_o is 1 once a planted 1 reaches track_o[REJECT_STAGE-1]. With the default of stage 5, this is bit 4, four move pulses after entry.
- R6: A removed_i pulse with move_i low drives reject_o to 0 from the next cycle. reject_o stays 0 until a move pulse occurs.
- R7: A move pulse clears the removal acknowledge, so a flagged bit that arrives in the reject stage raises reject_o again.
- R8: reject_o is 0 whenever track_o[REJECT_STAGE-1] is 0, so it stays low while good items pass the reject point.
- R9: clr_i high at an edge empties track_o and clears the acknowledge. It has priority over fault_i and move_i in the same cycle.
- R10: A removed_i pulse in the same cycle as a move pulse has no effect. The acknowledge is clear after that edge, and reject_o follows the new reject-stage bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of all tracking state |
| fault_i | input | 1 | Inspection-sensor fault pulse |
| move_i | input | 1 | Conveyor movement pulse, one per item |
| removed_i | input | 1 | Ejection confirmation pulse |
| reject_o | output | 1 | Reject actuator command |
| track_o | output | DEPTH | Tracking bits, index 0 is the entry stage |

## Verification
A single flagged item is walked from entry to the reject stage, with checks of when the command rises and when a removal pulse drops it. A second flagged bit trailing behind the first shows that the acknowledge is re-armed by the next move. Sparse patterns mixing good and bad items tell a flagged arrival apart from a good one at the reject point. Same-cycle combinations (fault with move, removal with move, clear with everything) exercise the ordering and priority rules, and a bit pushed past the last stage shows overflow loss.

// File: rtl/reject_pkg.sv
// Package reject_pkg
// Shared control type for the reject tracker. The arbiter builds one
// control word each cycle, and the tracking register consumes it.
package reject_pkg;

    // Per-cycle update request for the tracking register.
    typedef struct packed {
        logic clear;  // empty every stage
        logic shift;  // advance by one stage
        logic enter;  // write a 1 into stage 0 after any shift
    } trk_ctl_t;

endpackage

// File: rtl/rt_entry_arbiter.sv
// Module rt_entry_arbiter
// Orders the requests that act on the tracking register.
// - Reset and clear win over everything else.
// - A fault entry that meets a shift is deferred to after the shift.
// Assumes all inputs are single-cycle synchronous pulses.
module rt_entry_arbiter
    import reject_pkg::*;
(
    input  logic     rst_n,
    input  logic     clr_i,
    input  logic     fault_i,
    input  logic     move_i,
    output trk_ctl_t ctl_o
);

    logic clear_req;

    // Combine the reset and the clear into one clear request.
    always_comb clear_req = !rst_n || clr_i;

    // Build the control word, with clear masking the other requests.
    always_comb begin
        ctl_o.clear = clear_req;
        ctl_o.shift = move_i && !clear_req;
        ctl_o.enter = fault_i && !clear_req;
    end

endmodule

// File: rtl/rt_track_shreg.sv
// Module rt_track_shreg
// Tracking shift register, one flop per conveyor position.
// - Stage 0 is the entry point; a bit shifted out of the top stage is lost.
// - When enter and shift coincide, stage 0 takes the new 1 after the shift.
// Assumes that ctl_i is already prioritised by the arbiter.
module rt_track_shreg
    import reject_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  trk_ctl_t         ctl_i,
    output logic [DEPTH-1:0] q_o
);

    logic [DEPTH-1:0] q;

    // Entry stage: clear, then a new entry, then a shifted-in 0, then hold.
    always_ff @(posedge clk) begin
        if (ctl_i.clear)      q[0] <= 1'b0;
        else if (ctl_i.enter) q[0] <= 1'b1;
        else if (ctl_i.shift) q[0] <= 1'b0;
    end

    // Downstream stages: each one takes its upstream neighbour on a shift.
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (ctl_i.clear)      q[i] <= 1'b0;
            else if (ctl_i.shift) q[i] <= q[i-1];
        end
    end

    // Drive the register contents out.
    always_comb q_o = q;

endmodule

// File: rtl/rt_reject_latch.sv
// Module rt_reject_latch
// Reject command with a removal acknowledge.
// - Removal confirmation sets the acknowledge, which masks the command.
// - Any move clears the acknowledge; a move wins over a removal.
// Assumes that flag_i comes from a register, so reject_o has no input path.
module rt_reject_latch (
    input  logic clk,
    input  logic clear_i,
    input  logic move_i,
    input  logic removed_i,
    input  logic flag_i,
    output logic reject_o
);

    logic ack_q;

    // Acknowledge flag: cleared by clear or a move, set by a removal.
    always_ff @(posedge clk) begin
        if (clear_i || move_i) ack_q <= 1'b0;
        else if (removed_i)    ack_q <= 1'b1;
    end

    // Command is up when a flagged item sits at the reject point and has not been acknowledged.
    always_comb reject_o = flag_i && !ack_q;

endmodule

// File: rtl/reject_tracker.sv
// Module reject_tracker
// Top of the conveyor reject tracker.
// - Tracks flagged items through DEPTH positions.
// - Commands an ejection at position REJECT_STAGE, counted from 1.
// Assumes synchronous single-cycle input pulses and a synchronous active-low reset.
module reject_tracker
    import reject_pkg::*;
#(
    parameter int DEPTH        = 8,
    parameter int REJECT_STAGE = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             fault_i,
    input  logic             move_i,
    input  logic             removed_i,
    output logic             reject_o,
    output logic [DEPTH-1:0] track_o
);

    localparam int RIDX = REJECT_STAGE - 1;

    trk_ctl_t ctl;

    // Reject the parameter combinations that cannot work.
    initial begin
        if (REJECT_STAGE < 2 || REJECT_STAGE > DEPTH)
            $error("reject_tracker: REJECT_STAGE must lie in 2..DEPTH");
    end

    rt_entry_arbiter u_arb (
        .rst_n   (rst_n),
        .clr_i   (clr_i),
        .fault_i (fault_i),
        .move_i  (move_i),
        .ctl_o   (ctl)
    );

    rt_track_shreg #(.DEPTH(DEPTH)) u_trk (
        .clk   (clk),
        .ctl_i (ctl),
        .q_o   (track_o)
    );

    rt_reject_latch u_rej (
        .clk       (clk),
        .clear_i   (ctl.clear),
        .move_i    (ctl.shift),
        .removed_i (removed_i),
        .flag_i    (track_o[RIDX]),
        .reject_o  (reject_o)
    );

endmodule

// File: rtl/rt_checker.sv
// Module rt_checker
// Assertions for reject_tracker, bound to every instance of it.
module rt_checker #(
    parameter int DEPTH        = 8,
    parameter int REJECT_STAGE = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             fault_i,
    input logic             move_i,
    input logic             removed_i,
    input logic             reject_o,
    input logic [DEPTH-1:0] track_o
);

    localparam int RIDX = REJECT_STAGE - 1;

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (track_o == '0) && !reject_o);  // R9

    AST_SHIFT_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && move_i) |=> track_o[DEPTH-1:1] == $past(track_o[DEPTH-2:0]));  // R3

    AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && fault_i) |=> track_o[0]);  // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !move_i) |=> $stable(track_o[DEPTH-1:1]));  // R2

    AST_GOOD_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !track_o[RIDX] |-> !reject_o);  // R8

    AST_REMOVE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && removed_i && !move_i) |=> !reject_o);  // R6

    AST_ARRIVE_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && move_i && track_o[RIDX-1]) |=> reject_o);  // R7

endmodule

bind reject_tracker rt_checker #(.DEPTH(DEPTH), .REJECT_STAGE(REJECT_STAGE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .fault_i   (fault_i),
    .move_i    (move_i),
    .removed_i (removed_i),
    .reject_o  (reject_o),
    .track_o   (track_o)
);

// File: tb/sim_reject_tracker.sv
`timescale 1ns/1ps
module sim_reject_tracker;

    localparam int DEPTH = 8;
    localparam int REJECT_STAGE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_i = 1'b0, fault_i = 1'b0, move_i = 1'b0, removed_i = 1'b0;
    logic reject_o;
    logic [DEPTH-1:0] track_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    reject_tracker #(.DEPTH(DEPTH), .REJECT_STAGE(REJECT_STAGE)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .fault_i(fault_i),
        .move_i(move_i), .removed_i(removed_i),
        .reject_o(reject_o), .track_o(track_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock with the given pulses; outputs are sampled 1 ns after the edge.
    task automatic cyc(input logic f, input logic m, input logic r, input logic c);
        @(negedge clk);
        fault_i = f; move_i = m; removed_i = r; clr_i = c;
        @(posedge clk);
        #1;
        fault_i = 0; move_i = 0; removed_i = 0; clr_i = 0;
    endtask

    task automatic expect_state(input string req, input logic [7:0] trk, input logic rej);
        check(req, {8'h0, track_o}, {8'h0, trk});
        check(req, {15'h0, reject_o}, {15'h0, rej});
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 0; fault_i = 1; move_i = 1;
        @(posedge clk); #1;
        expect_state("R1 reset", 8'h00, 1'b0);
        fault_i = 0; move_i = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic t_walk;
        cyc(1, 0, 0, 0); expect_state("R2 entry", 8'h01, 0);
        cyc(1, 0, 0, 0); expect_state("R2 repeat entry", 8'h01, 0);
        cyc(0, 1, 0, 0); expect_state("R3 shift1", 8'h02, 0);
        cyc(0, 1, 0, 0); expect_state("R3 shift2", 8'h04, 0);
        cyc(0, 1, 0, 0); expect_state("R3 shift3", 8'h08, 0);
        cyc(0, 1, 0, 0); expect_state("R5 arrive", 8'h10, 1);
        cyc(0, 0, 0, 0); expect_state("R5 held", 8'h10, 1);
    endtask

    task automatic t_remove_rearm;
        cyc(0, 0, 1, 0); expect_state("R6 removed", 8'h10, 0);
        cyc(0, 0, 0, 0); expect_state("R6 stays off", 8'h10, 0);
        cyc(1, 0, 0, 0); expect_state("R6 entry keeps off", 8'h11, 0);
        cyc(0, 1, 0, 0); expect_state("R8 good at stage", 8'h22, 0);
        cyc(0, 1, 0, 0); expect_state("R3 shift", 8'h44, 0);
        cyc(0, 1, 0, 0); expect_state("R3 shift", 8'h88, 0);
        cyc(0, 1, 0, 0); expect_state("R7 rearm and R3 overflow", 8'h10, 1);
    endtask

    task automatic t_same_cycle;
        cyc(0, 0, 0, 1); expect_state("R9 clear", 8'h00, 0);
        cyc(1, 0, 0, 0); expect_state("R2 entry", 8'h01, 0);
        cyc(1, 1, 0, 0); expect_state("R4 fault with move", 8'h03, 0);
        cyc(1, 1, 1, 1); expect_state("R9 clear priority", 8'h00, 0);
    endtask

    task automatic t_mixed;
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(1, 1, 0, 0); expect_state("R4 pattern", 8'h05, 0);
        cyc(0, 1, 0, 0); expect_state("R8 pattern", 8'h0A, 0);
        cyc(0, 1, 0, 0); expect_state("R5 pattern", 8'h14, 1);
        cyc(0, 0, 1, 0); expect_state("R6 pattern", 8'h14, 0);
        cyc(0, 1, 0, 0); expect_state("R8 good passes", 8'h28, 0);
        cyc(0, 1, 0, 0); expect_state("R7 next flag", 8'h50, 1);
        cyc(0, 1, 1, 0); expect_state("R10 removal with move", 8'hA0, 0);
    endtask

    task automatic t_remove_with_move;
        cyc(0, 0, 0, 1);
        cyc(1, 0, 0, 0);
        cyc(1, 1, 0, 0);
        cyc(0, 1, 0, 0);
        cyc(0, 1, 0, 0); expect_state("R5 double", 8'h0C, 0);
        cyc(0, 1, 0, 0); expect_state("R5 double arrive", 8'h18, 1);
        cyc(0, 1, 1, 0); expect_state("R10 removal ignored", 8'h30, 1);
        cyc(0, 0, 1, 0); expect_state("R6 after", 8'h30, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_walk();
        t_remove_rearm();
        t_same_cycle();
        t_mixed();
        t_remove_with_move();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule